// File: doc/BRIEF.md
# Trace Output Region Walker

This block tells a trace buffer writer where its next bytes belong. Software points it at a table of 64-bit output-region descriptors, names the entry to start from and gives a byte offset into that entry's region. The walker reads the entry through a simple memory read port and checks it against a fixed set of legality rules. It then either loads the entry as the current data region or follows it as a link to another table. The current write address is the region base plus the running offset.

The writer reports the bytes it has consumed through an advance strobe. When the offset reaches the region size, the walker reads the next entry. A link entry replaces the table base and restarts at index 0, so a link that points back at its own table gives a circular buffer. Region descriptors can ask for an interrupt pulse or a halt when the region fills. Any malformed descriptor, and any bad software load, latches a sticky error code and freezes the walk until software loads the walker again.

Top module: `trace_region_walker`

## Requirements
- R1: After reset, `busy`, `err`, `stop_req`, `int_req` and `mem_rd_req` are 0, `err_code` is 0 and `cur_addr` is 0.
- R2: A load with a legal table base issues one read at `table_base + 8*index` in the cycle after the load. `busy` is high from that cycle until the region is accepted, and `busy` falls two cycles after the load edge with `cur_addr = region base + offset`.
- R3: Descriptor layout: bit 0 is the link flag, bit 2 is the interrupt flag, bit 4 is the halt flag, bits 9:6 are a size code giving a size of 4096 << code bytes, and bits 63:12 are the base. A descriptor with any other bit set gives error code 1.
- R4: A load whose table base has any of bits 11:0 set gives error code 2 one cycle after the load, with no memory read.
- R5: A loaded table base, a region base or a link base with any bit at or above `PA_W` set gives error code 3.
- R6: A link entry that also sets the interrupt flag or the halt flag gives error code 4.
- R7: A link entry at index 0 gives error code 5.
- R8: With `SINGLE_ENTRY` = 1, entry 1 must be a link whose base equals the current table base. Otherwise error code 6 results. With `SINGLE_ENTRY` = 0, these rules do not apply.
- R9: A region base that is not aligned to its own size gives error code 7.
- R10: When a region is loaded, an offset greater than or equal to its size gives error code 8. An offset of size-1 is legal.
- R11: Each advance adds `adv_len` to the offset. When the sum reaches the size, the remainder becomes the new offset and the walker reads entry index+1. A link entry loads its base as the new table and reads index 0 of that table. Crossing a link keeps `busy` high for 4 cycles after the advance edge.
- R12: When a region with the interrupt flag fills, `int_req` is high for exactly one cycle. When a region with the halt flag fills, `stop_req` goes high and stays high, no further reads occur, and advances are ignored until a reload.
- R13: An error holds `err` high with a stable `err_code`, issues no reads and ignores advances until the next load. A load clears the error. When several rules fail, the lowest code is reported.
- R14: An advance while `busy` is high has no effect on the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Software reload strobe |
| load_base | input | 64 | Table base to load |
| load_idx | input | IDX_W | Starting entry index |
| load_offset | input | 28 | Starting byte offset in the region |
| adv | input | 1 | Bytes-consumed strobe |
| adv_len | input | LEN_W | Bytes consumed |
| mem_rd_req | output | 1 | Descriptor read request |
| mem_rd_addr | output | 64 | Descriptor read address |
| mem_rd_data | input | 64 | Descriptor, valid the cycle after the request |
| busy | output | 1 | Walk in progress, no valid region yet |
| cur_addr | output | 64 | Current write address |
| int_req | output | 1 | One-cycle interrupt request |
| stop_req | output | 1 | Halt request, held |
| err | output | 1 | Sticky operation error |
| err_code | output | 4 | Code of the latched error |

## Verification
A wrong internal state usually shows first on the read port. A bad index or table base gives a wrong `mem_rd_addr` in the cycle after the load or after a fill. A stuck walk state leaves `busy` high beyond its fixed two or four cycles. A wrong offset or region register shows in `cur_addr` as soon as `busy` falls. A lost flag shows as a missing or stretched `int_req` pulse on the cycle after the filling advance. A wrongly ordered rule check shows as the wrong `err_code` two cycles after the read is issued.

// File: rtl/trw_pkg.sv
// Shared constants and types for the trace output region walker.
// Assumes 64-bit descriptors and 4 KB-aligned tables.
package trw_pkg;
    localparam int DESC_W     = 64;
    localparam int PAGE_SH    = 12;
    localparam int SZ_CODE_W  = 4;
    localparam int SZ_LSB     = 6;
    localparam int LINK_BIT   = 0;
    localparam int INT_BIT    = 2;
    localparam int HALT_BIT   = 4;
    localparam int REGION_W   = PAGE_SH + (1 << SZ_CODE_W);
    localparam logic [DESC_W-1:0] LEGAL_MASK = 64'hFFFF_FFFF_FFFF_F3D5;

    typedef enum logic [3:0] {
        ERR_NONE         = 4'd0,
        ERR_RSVD         = 4'd1,
        ERR_TBL_ALIGN    = 4'd2,
        ERR_ADDR_HIGH    = 4'd3,
        ERR_LINK_FLAGS   = 4'd4,
        ERR_LINK_AT0     = 4'd5,
        ERR_SINGLE       = 4'd6,
        ERR_REGION_ALIGN = 4'd7,
        ERR_OFFSET       = 4'd8
    } trw_err_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_RUN, ST_HALT, ST_ERR
    } trw_state_e;
endpackage

// File: rtl/trw_desc_check.sv
// Decodes one descriptor and applies the legality rules in priority order.
// Assumes the descriptor, index, table base and offset are all stable in the check cycle.
module trw_desc_check
    import trw_pkg::*;
#(
    parameter int PA_W         = 52,
    parameter int IDX_W        = 9,
    parameter bit SINGLE_ENTRY = 1'b0
) (
    input  logic [DESC_W-1:0]   desc,
    input  logic [IDX_W-1:0]    idx,
    input  logic [63:0]         table_base,
    input  logic [REGION_W-1:0] offset,
    output trw_err_e            err_code,
    output logic                is_link,
    output logic                flag_int,
    output logic                flag_halt,
    output logic [63:0]         base,
    output logic [REGION_W-1:0] size
);
    localparam logic [63:0] HIGH_MASK = ~((64'd1 << PA_W) - 64'd1);

    logic [SZ_CODE_W-1:0] code;

    // Field decode.
    always_comb begin
        code      = desc[SZ_LSB +: SZ_CODE_W];
        is_link   = desc[LINK_BIT];
        flag_int  = desc[INT_BIT];
        flag_halt = desc[HALT_BIT];
        base      = {desc[63:PAGE_SH], {PAGE_SH{1'b0}}};
        size      = REGION_W'(1) << (PAGE_SH + int'(code));
    end

    // Rule evaluation, lowest code wins.
    always_comb begin
        err_code = ERR_NONE;
        if (|(desc & ~LEGAL_MASK))
            err_code = ERR_RSVD;
        else if (|(base & HIGH_MASK))
            err_code = ERR_ADDR_HIGH;
        else if (is_link && (flag_int || flag_halt))
            err_code = ERR_LINK_FLAGS;
        else if (is_link && idx == '0)
            err_code = ERR_LINK_AT0;
        else if (SINGLE_ENTRY && idx == IDX_W'(1) && (!is_link || base != table_base))
            err_code = ERR_SINGLE;
        else if (!is_link && |(base[REGION_W-1:0] & (size - REGION_W'(1))))
            err_code = ERR_REGION_ALIGN;
        else if (!is_link && offset >= size)
            err_code = ERR_OFFSET;
    end
endmodule

// File: rtl/trw_offset_adv.sv
// Adds consumed bytes to the region offset and detects a region fill.
// Assumes the advance length never exceeds the widest region.
module trw_offset_adv
    import trw_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic [REGION_W-1:0] offset,
    input  logic [LEN_W-1:0]    len,
    input  logic [REGION_W-1:0] size,
    output logic [REGION_W-1:0] next_offset,
    output logic                wrap
);
    logic [REGION_W:0] sum;
    logic [REGION_W:0] rem;

    // Sum, fill test and remainder.
    always_comb begin
        sum         = {1'b0, offset} + (REGION_W+1)'(len);
        rem         = sum - {1'b0, size};
        wrap        = sum >= {1'b0, size};
        next_offset = wrap ? rem[REGION_W-1:0] : sum[REGION_W-1:0];
    end
endmodule

// File: rtl/trace_region_walker.sv
// Walks a linked table of output-region descriptors and produces the write address.
// Assumes memory returns read data the cycle after mem_rd_req; load has priority over all else.
module trace_region_walker
    import trw_pkg::*;
#(
    parameter int PA_W         = 52,
    parameter int IDX_W        = 9,
    parameter int LEN_W        = 8,
    parameter bit SINGLE_ENTRY = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [63:0]         load_base,
    input  logic [IDX_W-1:0]    load_idx,
    input  logic [REGION_W-1:0] load_offset,
    input  logic                adv,
    input  logic [LEN_W-1:0]    adv_len,
    output logic                mem_rd_req,
    output logic [63:0]         mem_rd_addr,
    input  logic [63:0]         mem_rd_data,
    output logic                busy,
    output logic [63:0]         cur_addr,
    output logic                int_req,
    output logic                stop_req,
    output logic                err,
    output logic [3:0]          err_code
);
    localparam logic [63:0] HIGH_MASK = ~((64'd1 << PA_W) - 64'd1);

    trw_state_e          state;
    trw_err_e            err_q;
    logic [63:0]         tbl_base;
    logic [IDX_W-1:0]    idx;
    logic [REGION_W-1:0] offset;
    logic [63:0]         reg_base;
    logic [REGION_W-1:0] reg_size;
    logic                reg_int;
    logic                reg_halt;
    logic                int_q;

    trw_err_e            chk_err;
    logic                chk_link;
    logic                chk_int;
    logic                chk_halt;
    logic [63:0]         chk_base;
    logic [REGION_W-1:0] chk_size;
    logic [REGION_W-1:0] adv_next;
    logic                adv_wrap;

    trw_desc_check #(
        .PA_W(PA_W), .IDX_W(IDX_W), .SINGLE_ENTRY(SINGLE_ENTRY)
    ) u_check (
        .desc(mem_rd_data), .idx(idx), .table_base(tbl_base), .offset(offset),
        .err_code(chk_err), .is_link(chk_link), .flag_int(chk_int),
        .flag_halt(chk_halt), .base(chk_base), .size(chk_size)
    );

    trw_offset_adv #(.LEN_W(LEN_W)) u_adv (
        .offset(offset), .len(adv_len), .size(reg_size),
        .next_offset(adv_next), .wrap(adv_wrap)
    );

    // Walk state, table pointer, region registers and error latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            err_q    <= ERR_NONE;
            tbl_base <= '0;
            idx      <= '0;
            offset   <= '0;
            reg_base <= '0;
            reg_size <= '0;
            reg_int  <= 1'b0;
            reg_halt <= 1'b0;
            int_q    <= 1'b0;
        end else begin
            int_q <= 1'b0;
            if (load) begin
                tbl_base <= load_base;
                idx      <= load_idx;
                offset   <= load_offset;
                err_q    <= ERR_NONE;
                if (|load_base[PAGE_SH-1:0]) begin
                    state <= ST_ERR;
                    err_q <= ERR_TBL_ALIGN;
                end else if (|(load_base & HIGH_MASK)) begin
                    state <= ST_ERR;
                    err_q <= ERR_ADDR_HIGH;
                end else begin
                    state <= ST_FETCH;
                end
            end else begin
                case (state)
                    ST_FETCH: state <= ST_CHECK;
                    ST_CHECK: begin
                        if (chk_err != ERR_NONE) begin
                            state <= ST_ERR;
                            err_q <= chk_err;
                        end else if (chk_link) begin
                            tbl_base <= chk_base;
                            idx      <= '0;
                            state    <= ST_FETCH;
                        end else begin
                            reg_base <= chk_base;
                            reg_size <= chk_size;
                            reg_int  <= chk_int;
                            reg_halt <= chk_halt;
                            state    <= ST_RUN;
                        end
                    end
                    ST_RUN: begin
                        if (adv) begin
                            offset <= adv_next;
                            if (adv_wrap) begin
                                int_q <= reg_int;
                                if (reg_halt) begin
                                    state <= ST_HALT;
                                end else begin
                                    idx   <= idx + IDX_W'(1);
                                    state <= ST_FETCH;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Port view of the walk state.
    always_comb begin
        mem_rd_req  = (state == ST_FETCH);
        mem_rd_addr = tbl_base + (64'(idx) << 3);
        busy        = (state == ST_FETCH) || (state == ST_CHECK);
        cur_addr    = reg_base + 64'(offset);
        int_req     = int_q;
        stop_req    = (state == ST_HALT);
        err         = (state == ST_ERR);
        err_code    = err_q;
    end
endmodule

// File: rtl/trw_checker.sv
// Protocol and stickiness properties of the walker, bound to its top module.
// Assumes the synchronous active-low reset of the walker.
module trw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        load,
    input logic        mem_rd_req,
    input logic        busy,
    input logic        err,
    input logic [3:0]  err_code,
    input logic        int_req,
    input logic        stop_req,
    input logic [63:0] cur_addr
);
    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> busy); // R2
    AST_READ_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !load |=> !mem_rd_req); // R2
    AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> err_code != 4'd0); // R13
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err && !load |=> err && $stable(err_code)); // R13
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_rd_req && !busy); // R13
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req && !load |=> stop_req && !mem_rd_req && $stable(cur_addr)); // R12
    AST_INT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |=> !int_req); // R12
endmodule

bind trace_region_walker trw_checker u_trw_checker (
    .clk(clk), .rst_n(rst_n), .load(load), .mem_rd_req(mem_rd_req),
    .busy(busy), .err(err), .err_code(err_code), .int_req(int_req),
    .stop_req(stop_req), .cur_addr(cur_addr)
);

// File: tb/trace_region_walker_tb_top.sv
module trace_region_walker_tb_top;
    import trw_pkg::*;

    localparam int IDX_W = 9;
    localparam int LEN_W = 16;
    localparam logic [63:0] TBL_A = 64'h0000_0000_0001_0000;
    localparam logic [63:0] TBL_B = 64'h0000_0000_0002_0000;

    typedef struct packed {
        logic [63:0] desc;
        logic [3:0]  idx;
        logic [31:0] offs;
        logic [3:0]  code;
        logic [63:0] addr;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{64'h0000_0000_4000_0000, 4'd3, 32'h0010, 4'd0, 64'h4000_0010}, // R3 legal 4K
        '{64'h0000_0000_4020_0240, 4'd3, 32'h1234, 4'd0, 64'h4020_1234}, // R9 legal 2M
        '{64'h0000_0000_4000_0002, 4'd3, 32'h0000, 4'd1, 64'h0},         // R3 bit 1
        '{64'h0000_0000_4000_0800, 4'd3, 32'h0000, 4'd1, 64'h0},         // R3 bit 11
        '{64'h0010_0000_4000_0000, 4'd3, 32'h0000, 4'd3, 64'h0},         // R5 bit 52
        '{64'h0000_0000_0001_0005, 4'd3, 32'h0000, 4'd4, 64'h0},         // R6 link+int
        '{64'h0000_0000_0001_0011, 4'd3, 32'h0000, 4'd4, 64'h0},         // R6 link+halt
        '{64'h0000_0000_0001_0001, 4'd0, 32'h0000, 4'd5, 64'h0},         // R7 link at 0
        '{64'h0000_0000_4000_1240, 4'd3, 32'h0000, 4'd7, 64'h0},         // R9 misaligned 2M
        '{64'h0000_0000_4000_0000, 4'd3, 32'h1000, 4'd8, 64'h0},         // R10 offset=size
        '{64'h0000_0000_4000_0000, 4'd3, 32'h0FFF, 4'd0, 64'h4000_0FFF}, // R10 size-1
        '{64'h0000_0000_0001_0003, 4'd0, 32'h0000, 4'd1, 64'h0},         // R13 rsvd beats link0
        '{64'h0000_0000_0001_0005, 4'd0, 32'h0000, 4'd4, 64'h0}          // R13 flags beat link0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic [63:0] load_base = '0;
    logic [IDX_W-1:0] load_idx = '0;
    logic [REGION_W-1:0] load_offset = '0;
    logic adv = 1'b0;
    logic [LEN_W-1:0] adv_len = '0;

    logic rd_req0, rd_req1;
    logic [63:0] rd_addr0, rd_addr1;
    logic [63:0] rd_data0 = '0, rd_data1 = '0;
    logic busy0, busy1, int0, int1, stop0, stop1, err0, err1;
    logic [63:0] addr0, addr1;
    logic [3:0] code0, code1;

    logic [63:0] mem [16];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trace_region_walker #(.IDX_W(IDX_W), .LEN_W(LEN_W), .SINGLE_ENTRY(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .load(load), .load_base(load_base),
        .load_idx(load_idx), .load_offset(load_offset), .adv(adv), .adv_len(adv_len),
        .mem_rd_req(rd_req0), .mem_rd_addr(rd_addr0), .mem_rd_data(rd_data0),
        .busy(busy0), .cur_addr(addr0), .int_req(int0), .stop_req(stop0),
        .err(err0), .err_code(code0)
    );

    trace_region_walker #(.IDX_W(IDX_W), .LEN_W(LEN_W), .SINGLE_ENTRY(1'b1)) dut_single (
        .clk(clk), .rst_n(rst_n), .load(load), .load_base(load_base),
        .load_idx(load_idx), .load_offset(load_offset), .adv(adv), .adv_len(adv_len),
        .mem_rd_req(rd_req1), .mem_rd_addr(rd_addr1), .mem_rd_data(rd_data1),
        .busy(busy1), .cur_addr(addr1), .int_req(int1), .stop_req(stop1),
        .err(err1), .err_code(code1)
    );

    function automatic int midx(logic [63:0] a);
        return int'({a[17], a[5:3]});
    endfunction

    // Descriptor memory, one-cycle read latency per port.
    always_ff @(posedge clk) begin
        if (rd_req0) rd_data0 <= mem[midx(rd_addr0)];
        if (rd_req1) rd_data1 <= mem[midx(rd_addr1)];
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_load(logic [63:0] b, int i, logic [31:0] o);
        load = 1'b1; load_base = b; load_idx = IDX_W'(i); load_offset = REGION_W'(o);
        tick();
        load = 1'b0;
    endtask

    task automatic do_adv(int len);
        adv = 1'b1; adv_len = LEN_W'(len);
        tick();
        adv = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) mem[k] = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 busy", 64'(busy0), 64'd0);
        chk("R1 err", 64'(err0), 64'd0);
        chk("R1 code", 64'(code0), 64'd0);
        chk("R1 req", 64'(rd_req0), 64'd0);
        chk("R1 halt/int", 64'({stop0, int0}), 64'd0);
        chk("R1 addr", addr0, 64'd0);

        // Vector table: one descriptor per load.
        for (int v = 0; v < NVEC; v++) begin
            mem[int'(VECS[v].idx)] = VECS[v].desc;
            do_load(TBL_A, int'(VECS[v].idx), VECS[v].offs);
            tick(); tick();
            chk($sformatf("R3/R13 vec%0d code", v), 64'(code0), 64'(VECS[v].code));
            chk($sformatf("R13 vec%0d err", v), 64'(err0), 64'(VECS[v].code != 4'd0));
            if (VECS[v].code == 4'd0)
                chk($sformatf("R2 vec%0d addr", v), addr0, VECS[v].addr);
        end

        // R4 misaligned table base
        do_load(TBL_A + 64'h40, 0, 0);
        chk("R4 code", 64'(code0), 64'd2);
        tick();
        chk("R4 no read", 64'(rd_req0), 64'd0);

        // R5 loaded base above physical width
        do_load(64'h1000_0000_0001_0000, 0, 0);
        chk("R5 load code", 64'(code0), 64'd3);

        // R2 read timing
        mem[2] = 64'h0000_0000_4000_0000;
        do_load(TBL_A, 2, 32'h8);
        chk("R2 req", 64'({busy0, rd_req0}), 64'd3);
        chk("R2 addr", rd_addr0, TBL_A + 64'h10);
        tick();
        chk("R2 check cycle", 64'({busy0, rd_req0}), 64'd2);
        tick();
        chk("R2 ready", 64'({busy0, addr0 == 64'h4000_0008}), 64'd1);

        // R11 circular walk with R12 interrupt and R14 ignored advance
        mem[0] = 64'h0000_0000_5000_0000;
        mem[1] = 64'h0000_0000_5000_1004;
        mem[2] = 64'h0000_0000_0001_0001;
        do_load(TBL_A, 0, 32'hF00);
        tick(); tick();
        do_adv(32'h80);
        chk("R11 add", addr0, 64'h5000_0F80);
        do_adv(32'hA0);
        chk("R11 wrap fetch", 64'({busy0, rd_req0}), 64'd3);
        chk("R11 next idx", rd_addr0, TBL_A + 64'h8);
        do_adv(32'h40); // R14 ignored while busy
        tick();
        chk("R14 ignored adv", addr0, 64'h5000_1020);
        do_adv(32'hFE0);
        chk("R12 int pulse", 64'(int0), 64'd1);
        begin
            int cyc = 0;
            while (busy0 && cyc < 20) begin
                tick();
                cyc++;
                if (cyc == 1) chk("R12 int once", 64'(int0), 64'd0);
            end
            chk("R11 link cycles", 64'(cyc), 64'd4);
        end
        chk("R11 circular addr", addr0, 64'h5000_0000);

        // R12 halt
        mem[0] = 64'h0000_0000_5000_0010;
        do_load(TBL_A, 0, 32'hFF0);
        tick(); tick();
        do_adv(32'h10);
        chk("R12 halt", 64'({stop0, busy0}), 64'd2);
        do_adv(32'h5);
        tick();
        chk("R12 halt ignores adv", addr0, 64'h5000_0000);
        chk("R12 halt held", 64'({stop0, rd_req0}), 64'd2);

        // R13 sticky error, then reload clears
        mem[3] = 64'h0000_0000_4000_0002;
        do_load(TBL_A, 3, 0);
        tick(); tick();
        do_adv(32'h10);
        repeat (3) tick();
        chk("R13 sticky", 64'({err0, code0}), 64'h11);
        mem[3] = 64'h0000_0000_4000_0000;
        do_load(TBL_A, 3, 0);
        tick(); tick();
        chk("R13 cleared", 64'({err0, busy0, addr0 == 64'h4000_0000}), 64'd1);

        // R8 single-entry rules, with the multi-entry walker crossing to table B
        mem[0] = 64'h0000_0000_5000_0000;
        mem[1] = 64'h0000_0000_0002_0001;
        mem[8] = 64'h0000_0000_6000_0000;
        do_load(TBL_A, 0, 32'hFF0);
        tick(); tick();
        do_adv(32'h10);
        repeat (4) tick();
        chk("R8 single bad link", 64'(code1), 64'd6);
        chk("R11 table switch", addr0, 64'h6000_0000);
        chk("R8 multi unaffected", 64'(err0), 64'd0);
        mem[1] = 64'h0000_0000_0001_0001;
        do_load(TBL_A, 0, 32'hFF0);
        tick(); tick();
        do_adv(32'h10);
        repeat (4) tick();
        chk("R8 single good link", 64'({err1, busy1, addr1 == 64'h5000_0000}), 64'd1);
        mem[1] = 64'h0000_0000_5000_1000;
        do_load(TBL_A, 0, 32'hFF0);
        tick(); tick();
        do_adv(32'h10);
        tick(); tick();
        chk("R8 single region at 1", 64'(code1), 64'd6);

        done = 1'b1;
        finish_run();
    end
endmodule